// File: doc/BRIEF.md
# Scratchpad and Memory Command Engine

This block is the memory-command layer of a single-wire EEPROM slave. It sits behind a byte-level link layer that has already completed bus initialization and device selection. It receives one command byte and then serves one of three commands: reading back the scratchpad, copying the scratchpad into the memory array, or reading the memory array. Received bytes arrive as single-cycle strobes. Outgoing bytes are produced on request: the host side pulses a request, and the engine answers on the next cycle with a one-cycle valid strobe and the byte.

The engine holds an 8-byte scratchpad, a low and a high target-address register, and an ending-offset/status register. Behind these sits a 144-byte array that maps to block RAM. Bit 7 of the status register is the authorization-accepted flag, bit 5 is the partial-write flag, and bits 2:0 are the ending offset. The low three bits of the low address register are the starting offset. A copy needs the host to echo the two address bytes and the status byte exactly. It also needs a valid target, a clear partial-write flag and an unlocked 8-byte row. When a copy is authorized, the engine writes the whole scratchpad into the row and holds a busy flag until the programming-done input arrives. It then answers every request with 0xAA until a bus reset. Test access ports preload the scratchpad, the registers and the array.

Top module: `mce_engine`

## Requirements
- R1: After reset, busy and tx_valid are low, and a byte request made with no command returns 0xFF.
- R2: After command 0xAA, the engine returns the low address, then the high address, then the status byte. It then returns scratchpad bytes starting at offset T (the low address bits 2:0) and ending at offset E (status bits 2:0), which is E−T+1 bytes.
- R3: After the scratchpad data, the engine returns the bitwise inverse of a CRC-16 (reflected polynomial 0xA001, initial value 0) in two bytes, low byte first. The CRC covers the command byte and every byte sent before it.
- R4: Once the CRC has been sent, every further read-scratchpad request returns 0xFF.
- R5: After command 0x55, if the next three bytes equal the low address, the high address and the status byte, and if the target is below 144, status bit 5 is clear and the row (address/8) is not locked, then the engine sets status bit 7 and writes the 8 scratchpad bytes into the aligned row. Busy goes high on the third byte and stays high until prog_done. Requests made while busy return 0xFF.
- R6: If the pattern differs, the target is 144 or above, status bit 5 is set, or the row is locked, the engine does not write memory and status bit 7 stays clear. Requests then return 0xFF.
- R7: After a completed copy, every request returns 0xAA until a bus reset.
- R8: After command 0xF0 and a two-byte address (low byte first), the engine returns memory bytes from that address upward. Addresses of 0x90 and above return 0xFF.
- R9: A read-memory command leaves the address registers, the status byte and the scratchpad unchanged.
- R10: A bus reset at any point clears busy and returns the engine to waiting for a command.
- R11: Every byte request is answered exactly one cycle later with tx_valid, and tx_valid is never raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset seen by the link layer |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next outgoing byte |
| tx_valid | output | 1 | Response strobe, one cycle after tx_req |
| tx_byte | output | 8 | Outgoing byte |
| prog_done | input | 1 | Programming of a copied row is complete |
| busy | output | 1 | Copy in progress |
| row_lock | input | 18 | Per-row copy protection, bit n locks row n |
| pre_reg_we | input | 1 | Preload strobe for scratchpad and registers |
| pre_mem_we | input | 1 | Preload strobe for the memory array |
| pre_addr | input | 8 | Preload index: 0-7 scratchpad, 8 low address, 9 high address, 10 status; array address for memory |
| pre_data | input | 8 | Preload byte |

## Verification
The assertions assume that the host never raises tx_req in the same cycle as rx_valid. They also assume at least two idle cycles between byte requests, so that the registered memory read has settled. Preloads are assumed to happen only while the engine waits for a command. prog_done is assumed to arrive only after the row write has finished. The stimulus tasks issue each byte on its own cycle with idle gaps, preload only after a bus reset, and raise prog_done only after a dozen cycles of busy.

// File: rtl/mce_pkg.sv
package mce_pkg;
  typedef enum logic [3:0] {
    S_CMD, S_RSP, S_CPA, S_CPW, S_CPB, S_CPD, S_RMA, S_RMD, S_HALT
  } st_t;

  localparam logic [7:0] CMD_RSP = 8'hAA;
  localparam logic [7:0] CMD_CPY = 8'h55;
  localparam logic [7:0] CMD_RDM = 8'hF0;
  localparam logic [7:0] DONE_PAT = 8'hAA;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mce_scratch.sv
module mce_scratch #(
  parameter int SP_BYTES = 8,
  parameter int SW = $clog2(SP_BYTES + 3)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pre_we,
  input  logic [SW-1:0]         pre_sel,
  input  logic [7:0]            pre_data,
  input  logic                  set_aa,
  output logic [SP_BYTES*8-1:0] sp_flat,
  output logic [7:0]            ta1,
  output logic [7:0]            ta2,
  output logic [7:0]            es
);
  for (genvar g = 0; g < SP_BYTES; g++) begin : g_sp
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= '0;
      else if (pre_we && pre_sel == SW'(g)) b_q <= pre_data;
    end
    assign sp_flat[g*8 +: 8] = b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ta1 <= '0;
      ta2 <= '0;
      es  <= '0;
    end else begin
      if (pre_we && pre_sel == SW'(SP_BYTES))     ta1 <= pre_data;
      if (pre_we && pre_sel == SW'(SP_BYTES + 1)) ta2 <= pre_data;
      if (pre_we && pre_sel == SW'(SP_BYTES + 2)) es  <= pre_data;
      else if (set_aa)                            es[7] <= 1'b1;
    end
  end
endmodule

// File: rtl/mce_mem.sv
module mce_mem #(
  parameter int DEPTH = 144,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/mce_ctrl.sv
module mce_ctrl
  import mce_pkg::*;
#(
  parameter int SP_BYTES = 8,
  parameter int MEM_BYTES = 144,
  parameter int NROWS = MEM_BYTES / SP_BYTES,
  parameter int AW = $clog2(MEM_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_reset,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  tx_req,
  input  logic                  prog_done,
  input  logic [NROWS-1:0]      row_lock,
  input  logic [SP_BYTES*8-1:0] sp_flat,
  input  logic [7:0]            ta1,
  input  logic [7:0]            ta2,
  input  logic [7:0]            es,
  input  logic [7:0]            mem_rdata,
  output logic                  tx_valid,
  output logic [7:0]            tx_byte,
  output logic                  busy,
  output logic                  set_aa,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_waddr,
  output logic [7:0]            mem_wdata,
  output logic [AW-1:0]         mem_raddr
);
  localparam int OW = $clog2(SP_BYTES);
  localparam int IW = $clog2(SP_BYTES + 6);
  localparam int RW = $clog2(NROWS);
  localparam logic [15:0] MEM_TOP = 16'(MEM_BYTES);

  st_t           st;
  logic [IW-1:0] idx;
  logic [1:0]    cnt;
  logic          match;
  logic [15:0]   rm_addr;
  logic [15:0]   crc;
  logic [OW-1:0] wr_k;

  logic [7:0]    spb [SP_BYTES];
  for (genvar g = 0; g < SP_BYTES; g++) begin : g_unpack
    assign spb[g] = sp_flat[g*8 +: 8];
  end

  logic [OW-1:0] t_off, e_off, sp_sel;
  logic [OW:0]   nbytes;
  logic [IW-1:0] dend, rel;
  logic [7:0]    rs_byte, resp, row_full;
  logic          addr_ok, lock_hit, auth_ok, rm_in;

  always_comb begin
    t_off   = ta1[OW-1:0];
    e_off   = es[OW-1:0];
    nbytes  = {1'b0, e_off - t_off} + (OW+1)'(1);
    dend    = IW'(3) + IW'(nbytes);
    rel     = idx - IW'(3);
    sp_sel  = t_off + rel[OW-1:0];
    if (idx == IW'(0))             rs_byte = ta1;
    else if (idx == IW'(1))        rs_byte = ta2;
    else if (idx == IW'(2))        rs_byte = es;
    else if (idx < dend)           rs_byte = spb[sp_sel];
    else if (idx == dend)          rs_byte = ~crc[7:0];
    else if (idx == dend + IW'(1)) rs_byte = ~crc[15:8];
    else                           rs_byte = 8'hFF;

    addr_ok  = {ta2, ta1} < MEM_TOP;
    row_full = ta1 >> OW;
    lock_hit = addr_ok && row_lock[addr_ok ? row_full[RW-1:0] : '0];
    auth_ok  = match && (rx_byte == es) && addr_ok && !es[5] && !lock_hit;
    set_aa   = (st == S_CPA) && rx_valid && (cnt == 2'd2) && auth_ok && !bus_reset;

    rm_in    = rm_addr < MEM_TOP;
    case (st)
      S_RSP:   resp = rs_byte;
      S_CPD:   resp = DONE_PAT;
      S_RMD:   resp = rm_in ? mem_rdata : 8'hFF;
      default: resp = 8'hFF;
    endcase

    mem_we    = (st == S_CPW);
    mem_waddr = AW'({ta1[7:OW], wr_k});
    mem_wdata = spb[wr_k];
    mem_raddr = rm_in ? rm_addr[AW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      st       <= S_CMD;
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
      busy     <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      match    <= 1'b0;
      rm_addr  <= '0;
      crc      <= '0;
      wr_k     <= '0;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= resp;

      if (tx_req && st == S_RSP) begin
        if (idx < dend) crc <= crc16_byte(crc, resp);
        if (idx < dend + IW'(2)) idx <= idx + IW'(1);
      end
      if (tx_req && st == S_RMD && rm_addr != 16'hFFFF) rm_addr <= rm_addr + 16'd1;

      case (st)
        S_CMD: if (rx_valid) begin
          idx <= '0;
          cnt <= '0;
          if (rx_byte == CMD_RSP) begin
            st  <= S_RSP;
            crc <= crc16_byte(16'h0000, CMD_RSP);
          end else if (rx_byte == CMD_CPY) st <= S_CPA;
          else if (rx_byte == CMD_RDM)     st <= S_RMA;
          else                             st <= S_HALT;
        end
        S_CPA: if (rx_valid) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd0) match <= (rx_byte == ta1);
          else if (cnt == 2'd1) match <= match && (rx_byte == ta2);
          else if (auth_ok) begin
            st   <= S_CPW;
            busy <= 1'b1;
            wr_k <= '0;
          end else st <= S_HALT;
        end
        S_CPW: begin
          wr_k <= wr_k + OW'(1);
          if (wr_k == OW'(SP_BYTES - 1)) st <= S_CPB;
        end
        S_CPB: if (prog_done) begin
          st   <= S_CPD;
          busy <= 1'b0;
        end
        S_RMA: if (rx_valid) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd0) rm_addr[7:0] <= rx_byte;
          else begin
            rm_addr[15:8] <= rx_byte;
            st <= S_RMD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mce_engine.sv
module mce_engine #(
  parameter int SP_BYTES = 8,
  parameter int MEM_BYTES = 144,
  parameter int NROWS = MEM_BYTES / SP_BYTES,
  parameter int AW = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             tx_req,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             prog_done,
  output logic             busy,
  input  logic [NROWS-1:0] row_lock,
  input  logic             pre_reg_we,
  input  logic             pre_mem_we,
  input  logic [AW-1:0]    pre_addr,
  input  logic [7:0]       pre_data
);
  localparam int SW = $clog2(SP_BYTES + 3);

  logic [SP_BYTES*8-1:0] sp_flat;
  logic [7:0]            ta1, ta2, es, mem_rdata, ctl_wdata;
  logic                  set_aa, ctl_we;
  logic [AW-1:0]         ctl_waddr, mem_raddr;

  mce_scratch #(.SP_BYTES(SP_BYTES), .SW(SW)) u_scr (
    .clk(clk), .rst(rst), .pre_we(pre_reg_we), .pre_sel(pre_addr[SW-1:0]),
    .pre_data(pre_data), .set_aa(set_aa), .sp_flat(sp_flat),
    .ta1(ta1), .ta2(ta2), .es(es)
  );

  mce_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(ctl_we || pre_mem_we),
    .waddr(pre_mem_we ? pre_addr : ctl_waddr),
    .wdata(pre_mem_we ? pre_data : ctl_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  mce_ctrl #(.SP_BYTES(SP_BYTES), .MEM_BYTES(MEM_BYTES), .NROWS(NROWS), .AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .prog_done(prog_done),
    .row_lock(row_lock), .sp_flat(sp_flat), .ta1(ta1), .ta2(ta2), .es(es),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .busy(busy), .set_aa(set_aa), .mem_we(ctl_we), .mem_waddr(ctl_waddr),
    .mem_wdata(ctl_wdata), .mem_raddr(mem_raddr)
  );
endmodule

// File: rtl/mce_engine_chk.sv
module mce_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_reset,
  input logic       tx_req,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       busy,
  input logic       prog_done,
  input logic       mem_we
);
  // R11
  p_tx_answer_r11: assert property (@(posedge clk) disable iff (rst)
    tx_req && !bus_reset |=> tx_valid);
  // R11
  p_tx_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !tx_req |=> !tx_valid);
  // R5
  p_busy_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(prog_done || bus_reset || rst));
  // R5
  p_busy_ff_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && $past(busy) |-> tx_byte == 8'hFF);
  // R6
  p_write_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R10
  p_bus_reset_r10: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !busy && !tx_valid);
endmodule

bind mce_engine mce_engine_chk u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .tx_req(tx_req),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .busy(busy),
  .prog_done(prog_done), .mem_we(ctl_we)
);

// File: tb/tb_mce_engine.sv
module tb_mce_engine;
  localparam int MEMB = 144;
  localparam int NR = 18;

  logic clk = 0, rst = 1, bus_reset = 0, rx_valid = 0, tx_req = 0, prog_done = 0;
  logic pre_reg_we = 0, pre_mem_we = 0;
  logic [7:0] rx_byte = 0, pre_addr = 0, pre_data = 0;
  logic [NR-1:0] row_lock = '0;
  logic tx_valid, busy;
  logic [7:0] tx_byte;

  mce_engine dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic go = 0, req_q = 0;
  logic [7:0] m_sp [8];
  logic [7:0] m_ta1, m_ta2, m_es;
  logic [7:0] m_mem [MEMB];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) req_q <= tx_req && !bus_reset && !rst;
  always @(negedge clk) if (go) chk("R11 tx_valid timing", 16'(tx_valid), 16'(req_q));

  function automatic logic [15:0] crc_b(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic txr(output logic [7:0] b);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0; b = tx_byte;
    @(negedge clk);
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic set_reg(int sel, logic [7:0] v);
    @(negedge clk); pre_reg_we = 1; pre_addr = 8'(sel); pre_data = v;
    @(negedge clk); pre_reg_we = 0;
    if (sel < 8) m_sp[sel] = v;
    else if (sel == 8) m_ta1 = v;
    else if (sel == 9) m_ta2 = v;
    else m_es = v;
  endtask

  task automatic set_regs(logic [7:0] a1, logic [7:0] a2, logic [7:0] s);
    set_reg(8, a1); set_reg(9, a2); set_reg(10, s);
  endtask

  task automatic read_sp(string tag, int extra);
    logic [7:0] q[$];
    logic [15:0] c;
    logic [7:0] b;
    int t, n;
    t = m_ta1[2:0];
    n = ((int'(m_es[2:0]) - t + 8) % 8) + 1;
    q.push_back(m_ta1); q.push_back(m_ta2); q.push_back(m_es);
    for (int k = 0; k < n; k++) q.push_back(m_sp[(t + k) % 8]);
    c = crc_b(16'h0, 8'hAA);
    foreach (q[i]) c = crc_b(c, q[i]);
    q.push_back(~c[7:0]); q.push_back(~c[15:8]);
    for (int k = 0; k < extra; k++) q.push_back(8'hFF);
    rx(8'hAA);
    foreach (q[i]) begin
      txr(b);
      chk($sformatf("%s byte %0d", tag, i), 16'(b), 16'(q[i]));
    end
  endtask

  task automatic read_mem(string tag, logic [15:0] a, int n);
    logic [7:0] b;
    rx(8'hF0); rx(a[7:0]); rx(a[15:8]);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      txr(b);
      chk($sformatf("%s addr %h", tag, a + 16'(k)), 16'(b),
          16'((int'(a) + k < MEMB) ? m_mem[int'(a) + k] : 8'hFF));
    end
  endtask

  task automatic copy_cmd(logic [7:0] p1, logic [7:0] p2, logic [7:0] p3);
    rx(8'h55); rx(p1); rx(p2); rx(p3);
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    go = 1;
    chk("R1 busy after reset", 16'(busy), 0);
    chk("R1 tx_valid after reset", 16'(tx_valid), 0);
    txr(b); chk("R1 idle request", 16'(b), 16'hFF);

    for (int i = 0; i < MEMB; i++) begin
      @(negedge clk); pre_mem_we = 1; pre_addr = 8'(i); pre_data = 8'(i * 7 + 3);
      m_mem[i] = 8'(i * 7 + 3);
    end
    @(negedge clk); pre_mem_we = 0;
    for (int i = 0; i < 8; i++) set_reg(i, 8'(8'hC0 + i * 17));

    // full scratchpad read, CRC, then trailing FF
    set_regs(8'h08, 8'h00, 8'h07);
    read_sp("R2 R3 R4 full", 3);
    breset();
    // partial offsets
    set_regs(8'h13, 8'h00, 8'h05);
    read_sp("R2 R3 partial", 1);
    breset();

    // read memory
    read_mem("R8 mid", 16'h0010, 4);
    breset();
    read_mem("R8 end", 16'h008D, 5);
    breset();
    read_mem("R8 high byte", 16'h0105, 2);
    breset();
    read_sp("R9 after read memory", 0);
    breset();

    // mismatched pattern
    set_regs(8'h28, 8'h00, 8'h07);
    copy_cmd(8'h28, 8'h00, 8'h06);
    chk("R6 mismatch busy", 16'(busy), 0);
    txr(b); chk("R6 mismatch resp", 16'(b), 16'hFF);
    breset();
    read_mem("R6 mismatch row", 16'h0028, 8);
    breset();
    read_sp("R6 mismatch AA clear", 0);
    breset();

    // partial-write flag set
    set_regs(8'h28, 8'h00, 8'h27);
    copy_cmd(8'h28, 8'h00, 8'h27);
    chk("R6 PF busy", 16'(busy), 0);
    txr(b); chk("R6 PF resp", 16'(b), 16'hFF);
    breset();
    read_mem("R6 PF row", 16'h0028, 8);
    breset();

    // locked row 5
    row_lock = 18'(1 << 5);
    set_regs(8'h28, 8'h00, 8'h07);
    copy_cmd(8'h28, 8'h00, 8'h07);
    chk("R6 locked busy", 16'(busy), 0);
    breset();
    read_mem("R6 locked row", 16'h0028, 8);
    breset();
    row_lock = '0;

    // invalid target
    set_regs(8'h90, 8'h00, 8'h07);
    copy_cmd(8'h90, 8'h00, 8'h07);
    chk("R6 invalid busy", 16'(busy), 0);
    txr(b); chk("R6 invalid resp", 16'(b), 16'hFF);
    breset();

    // valid copy to row 5
    set_regs(8'h2B, 8'h00, 8'h07);
    copy_cmd(8'h2B, 8'h00, 8'h07);
    chk("R5 busy set", 16'(busy), 1);
    txr(b); chk("R5 resp while busy", 16'(b), 16'hFF);
    repeat (12) @(negedge clk);
    chk("R5 busy held", 16'(busy), 1);
    @(negedge clk); prog_done = 1;
    @(negedge clk); prog_done = 0;
    chk("R5 busy released", 16'(busy), 0);
    for (int i = 0; i < 8; i++) m_mem[8'h28 + i] = m_sp[i];
    m_es[7] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      txr(b); chk("R7 done pattern", 16'(b), 16'hAA);
    end
    breset();
    txr(b); chk("R10 idle after bus reset", 16'(b), 16'hFF);
    read_mem("R5 copied row", 16'h0027, 10);
    breset();
    read_sp("R5 AA flag set", 0);
    breset();

    // copy to last row, with bus reset during busy
    for (int i = 0; i < 8; i++) set_reg(i, 8'(8'h31 + i * 5));
    set_regs(8'h88, 8'h00, 8'h07);
    copy_cmd(8'h88, 8'h00, 8'h07);
    chk("R5 last row busy", 16'(busy), 1);
    repeat (10) @(negedge clk);
    breset();
    chk("R10 bus reset clears busy", 16'(busy), 0);
    for (int i = 0; i < 8; i++) m_mem[8'h88 + i] = m_sp[i];
    m_es[7] = 1'b1;
    read_mem("R5 last row", 16'h0088, 9);
    breset();

    // bus reset in the middle of a scratchpad read
    rx(8'hAA);
    txr(b); chk("R2 first byte", 16'(b), 16'(m_ta1));
    breset();
    read_mem("R10 new command after reset", 16'h0000, 2);
    breset();

    go = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule